// File: doc/BRIEF.md
# Fuse Word Read Controller

This block lets a host read 16-bit words from a small one-time-programmable fuse array through a register window. The host writes a block number, pulses a start bit, and waits for a sticky completion flag. It then takes the word from a read-data register and clears the flag with a separate command bit. The fuse array has 32 blocks. Its contents come from a parameter seed, and each word is the host-visible value of one block. The byte at position n of a block sits at bit 8·n of the returned word.

The controller works only while the external module-enable input is high. A read is accepted only in standby, which means enabled and idle. During a read, the sequencer holds the busy flag for a programmable number of clock cycles. Completion then raises the done flag, and standby returns in the same cycle. Programming is not supported: the program-start bit has no effect and the protect flag reads as set. Several scratch control registers keep whatever is written to them. All host accesses are single-cycle, and read data is available combinationally in the same cycle as the request.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset, the read-data register reads 0, the block index reads 0 and the read-timing register reads 4. With module enable high, status reads 0x0C: standby is bit 2 and protect is bit 3.
- R2: The scratch registers keep written values. Global control at 0x00 and write data at 0x08 keep 32 bits. Write timing at 0x20, read timing at 0x24 and debounce at 0x28 keep their low 8 bits. The block index at 0x0C keeps bits 4:0. All other bits read 0.
- R3: The mode-control register at 0x10 always reads 0. Any offset outside the map reads 0, and a write to such an offset changes no register.
- R4: Status bit 0 (program busy) always reads 0 and status bit 3 (protect) always reads 1.
- R5: Writing mode-control bit 1 in standby starts a read. Status bit 1 (read busy) is then high, and bit 2 (standby) low, for exactly N cycles, where N is the read-timing value and a value of 0 counts as 1.
- R6: The cycle busy falls, status bit 4 (read done) and standby are both high. Read data at 0x04 then holds the fuse word of the block index latched at start in bits 15:0, with bits 31:16 zero.
- R7: Read done stays set until mode-control bit 2 is written as 1. That write clears it.
- R8: A read start is ignored while module enable is low or while a read is in progress. A start during a read does not change the word the read returns.
- R9: Lowering module enable during a read returns the sequencer to idle by the next cycle. Busy then clears, done is not set, and the read-data register keeps its old value. Standby reads 0 while enable is low.
- R10: Writing mode-control bit 0 (program start) sets no status bit and starts no read.
- R11: The fuse word of block i is the low 16 bits of (i × 0x1357) XOR 0xA5C3, using the default seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modEn | input | 1 | Module enable; the controller acts only while high |
| busValid | input | 1 | Host access request this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the request cycle, 0 when idle |

## Verification
The assertions assume that the host issues at most one access per cycle and holds busValid low between accesses. They also assume that module enable changes only between clock edges. The bench drives every access and every enable change from the falling edge, and it sends each register access as a one-cycle pulse. Because done may legally stay set across later reads, the bench clears it before each directed scenario that expects it to stay low. The start-during-read case is issued well inside a long busy window, so no start can coincide with completion.

// File: rtl/fuse_rd_pkg.sv
`timescale 1ns/1ps
package fuse_rd_pkg;

  localparam int WORD_W = 16;

  localparam int OFS_GLB    = 'h00;
  localparam int OFS_RDATA  = 'h04;
  localparam int OFS_WDATA  = 'h08;
  localparam int OFS_BLK    = 'h0C;
  localparam int OFS_MODE   = 'h10;
  localparam int OFS_STAT   = 'h14;
  localparam int OFS_WRTIM  = 'h20;
  localparam int OFS_RDTIM  = 'h24;
  localparam int OFS_DEB    = 'h28;

  // mode-control bit positions
  localparam int MODE_PGM   = 0;
  localparam int MODE_START = 1;
  localparam int MODE_CLR   = 2;

  // status bit positions
  localparam int ST_PGM_BUSY = 0;
  localparam int ST_RD_BUSY  = 1;
  localparam int ST_STANDBY  = 2;
  localparam int ST_PROT     = 3;
  localparam int ST_DONE     = 4;

  typedef struct packed {
    logic latchIdx;   // capture block index at accepted start
    logic loadWord;   // capture fuse word into read-data register
    logic setDone;    // raise sticky done flag
  } seqStrobeT;

  function automatic logic [WORD_W-1:0] fuseWord(input int idx, input logic [WORD_W-1:0] seed);
    logic [31:0] prod;
    prod = 32'(idx) * 32'h1357;
    return prod[WORD_W-1:0] ^ seed;
  endfunction

endpackage

// File: rtl/fuse_rd_seq.sv
`timescale 1ns/1ps
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int TIM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modEn,
  input  logic             startReq,
  input  logic [TIM_W-1:0] rdTiming,
  output seqStrobeT        seqStrobe,
  output logic             rdBusy,
  output logic             standby
);

  typedef enum logic {SEQ_IDLE, SEQ_BUSY} seqStateT;

  seqStateT         state;
  logic [TIM_W-1:0] cnt;
  logic             accept;
  logic             finish;
  logic [TIM_W-1:0] loadVal;

  assign accept  = startReq && modEn && (state == SEQ_IDLE);
  assign finish  = modEn && (state == SEQ_BUSY) && (cnt == TIM_W'(1));
  assign loadVal = (rdTiming == '0) ? TIM_W'(1) : rdTiming;

  always_comb begin
    seqStrobe          = '0;
    seqStrobe.latchIdx = accept;
    seqStrobe.loadWord = finish;
    seqStrobe.setDone  = finish;
  end

  assign rdBusy  = (state == SEQ_BUSY);
  assign standby = modEn && (state == SEQ_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else if (!modEn) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (accept) begin
            state <= SEQ_BUSY;
            cnt   <= loadVal;
          end
        end
        SEQ_BUSY: begin
          if (finish) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - TIM_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fuse_rd_dp.sv
`timescale 1ns/1ps
module fuse_rd_dp
  import fuse_rd_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 32,
  parameter int              NUM_BLK    = 32,
  parameter int              TIM_W      = 8,
  parameter int              RD_TIM_RST = 4,
  parameter logic [WORD_W-1:0] FUSE_SEED = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  seqStrobeT         seqStrobe,
  input  logic              rdBusy,
  input  logic              standby,
  output logic              startReq,
  output logic [TIM_W-1:0]  rdTiming,
  output logic              rdDone
);

  localparam int IDX_W = $clog2(NUM_BLK);

  localparam logic [ADDR_W-1:0] A_GLB   = ADDR_W'(OFS_GLB);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(OFS_RDATA);
  localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(OFS_WDATA);
  localparam logic [ADDR_W-1:0] A_BLK   = ADDR_W'(OFS_BLK);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_WRTIM = ADDR_W'(OFS_WRTIM);
  localparam logic [ADDR_W-1:0] A_RDTIM = ADDR_W'(OFS_RDTIM);
  localparam logic [ADDR_W-1:0] A_DEB   = ADDR_W'(OFS_DEB);

  logic [WORD_W-1:0] fuseRom [NUM_BLK];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_rom
    assign fuseRom[g] = fuseWord(g, FUSE_SEED);
  end

  logic [DATA_W-1:0] glbCtrl;
  logic [DATA_W-1:0] wrData;
  logic [IDX_W-1:0]  blkIdx;
  logic [IDX_W-1:0]  blkLat;
  logic [TIM_W-1:0]  wrTim;
  logic [TIM_W-1:0]  rdTim;
  logic [TIM_W-1:0]  debCtrl;
  logic [WORD_W-1:0] rdWord;
  logic              doneFlag;
  logic              wrEn;
  logic              rdEn;
  logic              clrReq;

  assign wrEn     = busValid && busWrite;
  assign rdEn     = busValid && !busWrite;
  assign startReq = wrEn && (busAddr == A_MODE) && busWdata[MODE_START];
  assign clrReq   = wrEn && (busAddr == A_MODE) && busWdata[MODE_CLR];
  assign rdTiming = rdTim;
  assign rdDone   = doneFlag;

  // scratch and index registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glbCtrl <= '0;
      wrData  <= '0;
      blkIdx  <= '0;
      wrTim   <= '0;
      rdTim   <= TIM_W'(RD_TIM_RST);
      debCtrl <= '0;
    end else if (wrEn) begin
      unique case (busAddr)
        A_GLB:   glbCtrl <= busWdata;
        A_WDATA: wrData  <= busWdata;
        A_BLK:   blkIdx  <= busWdata[IDX_W-1:0];
        A_WRTIM: wrTim   <= busWdata[TIM_W-1:0];
        A_RDTIM: rdTim   <= busWdata[TIM_W-1:0];
        A_DEB:   debCtrl <= busWdata[TIM_W-1:0];
        default: ;
      endcase
    end
  end

  // read path registers driven by sequencer strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkLat   <= '0;
      rdWord   <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (seqStrobe.latchIdx) blkLat <= blkIdx;
      if (seqStrobe.loadWord) rdWord <= fuseRom[blkLat];
      if (seqStrobe.setDone)  doneFlag <= 1'b1;
      else if (clrReq)        doneFlag <= 1'b0;
    end
  end

  logic [DATA_W-1:0] statWord;

  always_comb begin
    statWord              = '0;
    statWord[ST_PGM_BUSY] = 1'b0;
    statWord[ST_RD_BUSY]  = rdBusy;
    statWord[ST_STANDBY]  = standby;
    statWord[ST_PROT]     = 1'b1;
    statWord[ST_DONE]     = doneFlag;
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      unique case (busAddr)
        A_GLB:   busRdata = glbCtrl;
        A_RDATA: busRdata = DATA_W'(rdWord);
        A_WDATA: busRdata = wrData;
        A_BLK:   busRdata = DATA_W'(blkIdx);
        A_STAT:  busRdata = statWord;
        A_WRTIM: busRdata = DATA_W'(wrTim);
        A_RDTIM: busRdata = DATA_W'(rdTim);
        A_DEB:   busRdata = DATA_W'(debCtrl);
        default: busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/fuse_rd_ctrl.sv
`timescale 1ns/1ps
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter int                NUM_BLK    = 32,
  parameter int                TIM_W      = 8,
  parameter int                RD_TIM_RST = 4,
  parameter logic [WORD_W-1:0] FUSE_SEED  = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modEn,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);

  seqStrobeT        seqStrobe;
  logic             rdBusy;
  logic             standby;
  logic             startReq;
  logic [TIM_W-1:0] rdTiming;
  logic             rdDone;

  fuse_rd_seq #(
    .TIM_W(TIM_W)
  ) seq_i (
    .clk      (clk),
    .rstN     (rstN),
    .modEn    (modEn),
    .startReq (startReq),
    .rdTiming (rdTiming),
    .seqStrobe(seqStrobe),
    .rdBusy   (rdBusy),
    .standby  (standby)
  );

  fuse_rd_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BLK   (NUM_BLK),
    .TIM_W     (TIM_W),
    .RD_TIM_RST(RD_TIM_RST),
    .FUSE_SEED (FUSE_SEED)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .seqStrobe(seqStrobe),
    .rdBusy   (rdBusy),
    .standby  (standby),
    .startReq (startReq),
    .rdTiming (rdTiming),
    .rdDone   (rdDone)
  );

endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_chk
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              modEn,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              rdBusy,
  input logic              standby,
  input logic              rdDone
);

  logic clrWrite;
  logic statRead;
  logic modeRead;

  assign clrWrite = busValid && busWrite && (busAddr == ADDR_W'(OFS_MODE)) && busWdata[MODE_CLR];
  assign statRead = busValid && !busWrite && (busAddr == ADDR_W'(OFS_STAT));
  assign modeRead = busValid && !busWrite && (busAddr == ADDR_W'(OFS_MODE));

  AST_BUSY_NOT_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    !(rdBusy && standby)); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rdDone && !clrWrite) |=> rdDone); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdDone) |-> (!rdBusy && $past(rdBusy))); // R6

  AST_EN_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> !rdBusy); // R9

  AST_EN_LOW_NO_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |-> !standby); // R9

  AST_MODE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    modeRead |-> (busRdata == '0)); // R3

  AST_STATUS_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    statRead |-> (busRdata[ST_PGM_BUSY] == 1'b0 && busRdata[ST_PROT] == 1'b1)); // R4

endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .modEn   (modEn),
  .busValid(busValid),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .rdBusy  (rdBusy),
  .standby (standby),
  .rdDone  (rdDone)
);

// File: tb/fuse_rd_ctrl_tb.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modEn = 1'b1;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  fuse_rd_ctrl dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .modEn   (modEn),
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata)
  );

  // {addr, write value, expected readback}
  localparam int NVEC = 15;
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h00, 32'h12345678, 32'h12345678},
    {8'h00, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {8'h08, 32'hCAFEF00D, 32'hCAFEF00D},
    {8'h08, 32'h00000000, 32'h00000000},
    {8'h0C, 32'h0000001F, 32'h0000001F},
    {8'h0C, 32'hFFFFFFE2, 32'h00000002},
    {8'h20, 32'h000000AB, 32'h000000AB},
    {8'h20, 32'h12345677, 32'h00000077},
    {8'h28, 32'h0000005A, 32'h0000005A},
    {8'h28, 32'hFFFFFF01, 32'h00000001},
    {8'h10, 32'h00000000, 32'h00000000},
    {8'h18, 32'hDEADBEEF, 32'h00000000},
    {8'h2C, 32'h11111111, 32'h00000000},
    {8'hFC, 32'hFFFFFFFF, 32'h00000000},
    {8'h24, 32'h00000103, 32'h00000003}
  };

  function automatic logic [15:0] expWord(input int i);
    logic [31:0] p;
    p = 32'(i) * 32'h1357;
    return p[15:0] ^ 16'hA5C3;
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    busValid = 1'b0; busWrite = 1'b0;
    @(negedge clk);
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // start a read and count busy cycles; st returns first non-busy status
  task automatic runRead(input int blk, input int tim, output int busyCnt,
                         output int sbyBad, output logic [31:0] st);
    busWr(8'h24, 32'(tim));
    busWr(8'h0C, 32'(blk));
    busWr(8'h10, 32'h2);
    busyCnt = 0;
    sbyBad  = 0;
    for (int i = 0; i < 400; i++) begin
      busRd(8'h14, st);
      if (!st[1]) break;
      busyCnt++;
      if (st[2]) sbyBad++;
    end
  endtask

  logic [31:0] rd;
  logic [31:0] st;
  logic [31:0] prevData;
  int          bc;
  int          sb;

  initial begin
    #600000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    busRd(8'h14, rd); check(rd, 32'h0000000C, "R1 status after reset");
    busRd(8'h04, rd); check(rd, 32'h0, "R1 read data after reset");
    busRd(8'h0C, rd); check(rd, 32'h0, "R1 block index after reset");
    busRd(8'h24, rd); check(rd, 32'h4, "R1 read timing after reset");

    // R2/R3 register table
    for (int v = 0; v < NVEC; v++) begin
      busWr(VEC[v][71:64], VEC[v][63:32]);
      busRd(VEC[v][71:64], rd);
      check(rd, VEC[v][31:0], $sformatf("R2/R3 vector %0d addr 0x%02h", v, VEC[v][71:64]));
    end
    // R3 unmapped write left others intact
    busRd(8'h08, rd); check(rd, 32'h0, "R3 wdata intact after unmapped writes");
    busRd(8'h28, rd); check(rd, 32'h1, "R3 debounce intact after unmapped writes");

    // R5/R6 normal read, timing 3
    runRead(5, 3, bc, sb, st);
    check(32'(bc), 32'd3, "R5 busy cycles timing 3");
    check(32'(sb), 32'd0, "R5 standby low while busy");
    check(st, 32'h0000001C, "R6 done and standby together");
    busRd(8'h04, rd); check(rd, {16'h0, expWord(5)}, "R6 word of block 5");
    check(32'(rd[7:0]), 32'(expWord(5) & 16'hFF), "R6 byte 0 at bit 0");

    // R7 sticky done
    idle(10);
    busRd(8'h14, rd); check(rd & 32'h10, 32'h10, "R7 done still set");
    busWr(8'h10, 32'h4);
    busRd(8'h14, rd); check(rd, 32'h0000000C, "R7 done cleared by clear bit");

    // R5 timing 0 behaves as 1
    runRead(31, 0, bc, sb, st);
    check(32'(bc), 32'd1, "R5 busy cycles timing 0");
    busRd(8'h04, rd); check(rd, {16'h0, expWord(31)}, "R11 word of block 31");

    // R11 more blocks, different timing
    runRead(0, 7, bc, sb, st);
    check(32'(bc), 32'd7, "R5 busy cycles timing 7");
    busRd(8'h04, rd); check(rd, {16'h0, expWord(0)}, "R11 word of block 0");
    runRead(17, 2, bc, sb, st);
    busRd(8'h04, rd); check(rd, {16'h0, expWord(17)}, "R11 word of block 17");

    // R8 start during busy ignored
    busWr(8'h10, 32'h4);
    busWr(8'h24, 32'd12);
    busWr(8'h0C, 32'd3);
    busWr(8'h10, 32'h2);
    idle(2);
    busWr(8'h0C, 32'd7);
    busWr(8'h10, 32'h2);
    idle(20);
    busRd(8'h04, rd); check(rd, {16'h0, expWord(3)}, "R8 restart while busy ignored");
    busRd(8'h14, rd); check(rd, 32'h0000001C, "R8 one completion only");

    // R8 start with enable low ignored
    busWr(8'h10, 32'h4);
    modEn = 1'b0;
    busWr(8'h10, 32'h2);
    busRd(8'h14, rd); check(rd, 32'h00000008, "R8/R9 enable low: no busy, no standby");
    modEn = 1'b1;
    idle(20);
    busRd(8'h14, rd); check(rd, 32'h0000000C, "R8 no read after enable low start");

    // R9 abort by dropping enable
    busRd(8'h04, prevData);
    busWr(8'h24, 32'd20);
    busWr(8'h0C, 32'd9);
    busWr(8'h10, 32'h2);
    busRd(8'h14, rd); check(rd & 32'h6, 32'h2, "R9 busy before abort");
    modEn = 1'b0;
    idle(1);
    busRd(8'h14, rd); check(rd, 32'h00000008, "R9 idle after enable drop");
    modEn = 1'b1;
    idle(30);
    busRd(8'h14, rd); check(rd, 32'h0000000C, "R9 no done after abort");
    busRd(8'h04, rd); check(rd, prevData, "R9 read data unchanged after abort");

    // R10 program start ignored
    busWr(8'h10, 32'h1);
    busRd(8'h14, rd); check(rd, 32'h0000000C, "R10 program start no effect");
    idle(5);
    busRd(8'h14, rd); check(rd, 32'h0000000C, "R4 fixed status bits");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule